// File: doc/BRIEF.md
# Diamond Fork/Join Arithmetic Stream

This block is a streaming arithmetic kernel laid out as a diamond. An entry stage scales every incoming 8-bit unsigned sample by three and hands the same product to two arms. The first arm adds 25 and the second doubles, and the two arms run side by side, each with its own buffering. An exit stage recombines them: it takes the first-arm result for a sample and adds twice the second-arm result for that same sample. The entry stage also tags each sample with its position in a frame of `FRAME_LEN` samples, so the output marks the end of every frame.

Every link uses a valid/ready handshake. Each arm is made of an input FIFO, a one-sample compute register and an output FIFO. The exit stage takes a sample only when both arm FIFOs hold one, and pops the two together. A new sample can enter on every cycle while earlier samples are still moving through the arms. Taken end to end, the block computes 15·x + 25 modulo 256.

Top module: `dfg_diamond`

## Requirements
- R1: After reset is released, out_valid is 0 and in_ready is 1.
- R2: Each output sample equals (x·3 + 25) + 2·(x·3·2) for its input x, with every step wrapping modulo 256. This is the same as (15·x + 25) mod 256, and it holds for all 256 input values.
- R3: Output samples leave in the order their inputs were accepted, with none lost and none repeated.
- R4: While out_ready stays 1 and input is offered on every cycle, in_ready never drops, and a burst of K samples leaves on K consecutive cycles.
- R5: The exit stage always pairs the two arm results that belong to the same input sample.
- R6: The exit stage pops its arm FIFOs only in a cycle when both are non-empty, and it always pops both together.
- R7: out_last is 1 exactly on the output sample whose accepted-input index modulo FRAME_LEN equals FRAME_LEN-1. The count starts at index 0 after reset.
- R8: The entry stage accepts nothing while either arm input FIFO is full. With out_ready held at 0 from an empty pipeline, exactly 2·FIFO_DEPTH+2 samples are accepted, and after that in_ready is 0.
- R9: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input sample is offered |
| in_data | input | 8 | Input sample, unsigned |
| in_ready | output | 1 | The entry stage can take a sample this cycle |
| out_valid | output | 1 | An output sample is present |
| out_data | output | 8 | Output sample |
| out_last | output | 1 | The output sample closes a frame |
| out_ready | input | 1 | The downstream consumer takes the output sample |

## Verification
The properties do not assume that in_valid or in_data stay stable while waiting. An input counts only in a cycle where in_valid and in_ready are both 1, so the stimulus is free to withdraw or change an offer. The frame-position property keeps its own count of accepted outputs starting from reset, so it depends on the block leaving no stale output from before reset. The stimulus always drives rst_n low for several cycles before any traffic. out_ready is driven from a pseudo-random sequence and is sometimes held low for long stretches, so the backpressure path is exercised up to full capacity in both arms.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
  localparam int SAMPLE_W = 8;
  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef struct packed {
    logic    last;
    sample_t data;
  } token_t;

  localparam int TOKEN_W = $bits(token_t);

  function automatic sample_t fn_scale3(input sample_t x);
    sample_t twice;
    twice = sample_t'(x << 1);
    return sample_t'(twice + x);
  endfunction

  function automatic sample_t fn_add25(input sample_t x);
    return sample_t'(x + sample_t'(25));
  endfunction

  function automatic sample_t fn_double(input sample_t x);
    return sample_t'(x << 1);
  endfunction

  function automatic sample_t fn_merge(input sample_t b, input sample_t c);
    return sample_t'(b + sample_t'(c << 1));
  endfunction
endpackage

// File: rtl/dfg_fifo.sv
module dfg_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wp, rp;

  assign empty = (wp == rp);
  assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign rdata = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && !empty) rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[AW-1:0]] <= wdata;
  end
endmodule

// File: rtl/dfg_fork.sv
module dfg_fork
  import dfg_pkg::*;
#(
  parameter int FRAME_LEN = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  sample_t in_data,
  output logic    in_ready,
  input  logic    b_full,
  input  logic    c_full,
  output logic    push,
  output token_t  tok
);
  localparam int CW = $clog2(FRAME_LEN);

  logic [CW-1:0] idx;
  logic          at_end;

  assign at_end   = (idx == CW'(FRAME_LEN - 1));
  assign in_ready = !b_full && !c_full;
  assign push     = in_valid && in_ready;
  assign tok.data = fn_scale3(in_data);
  assign tok.last = at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)    idx <= '0;
    else if (push) idx <= at_end ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/dfg_branch.sv
module dfg_branch
  import dfg_pkg::*;
#(
  parameter bit DOUBLE = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  token_t in_tok,
  output logic   in_pop,
  input  logic   out_full,
  output logic   out_push,
  output token_t out_tok
);
  logic    hold_v;
  token_t  hold_tok;
  sample_t res;

  generate
    if (DOUBLE) begin : g_dbl
      assign res = fn_double(in_tok.data);
    end else begin : g_add
      assign res = fn_add25(in_tok.data);
    end
  endgenerate

  assign out_push = hold_v && !out_full;
  assign in_pop   = in_valid && (!hold_v || out_push);
  assign out_tok  = hold_tok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_tok <= '0;
    end else if (in_pop) begin
      hold_v   <= 1'b1;
      hold_tok <= '{last: in_tok.last, data: res};
    end else if (out_push) begin
      hold_v <= 1'b0;
    end
  end
endmodule

// File: rtl/dfg_join.sv
module dfg_join
  import dfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    b_valid,
  input  token_t  b_tok,
  input  logic    c_valid,
  input  token_t  c_tok,
  output logic    pop,
  output logic    out_valid,
  output sample_t out_data,
  output logic    out_last,
  input  logic    out_ready
);
  assign pop = b_valid && c_valid && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (pop) begin
      out_valid <= 1'b1;
      out_data  <= fn_merge(b_tok.data, c_tok.data);
      out_last  <= b_tok.last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dfg_diamond.sv
module dfg_diamond
  import dfg_pkg::*;
#(
  parameter int FRAME_LEN  = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_last,
  input  logic       out_ready
);
  localparam int ARMS = 2;

  // named internal events, used by the bound checker
  logic            fork_push;
  token_t          fork_tok;
  logic [ARMS-1:0] arm_full;   // arm input FIFO full
  logic [ARMS-1:0] arm_empty;  // arm output FIFO empty
  token_t          arm_tok [ARMS];
  logic            join_pop;
  logic            join_b_last, join_c_last;

  dfg_fork #(.FRAME_LEN(FRAME_LEN)) u_fork (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .b_full(arm_full[0]), .c_full(arm_full[1]),
    .push(fork_push), .tok(fork_tok)
  );

  for (genvar k = 0; k < ARMS; k++) begin : g_arm
    token_t q_tok, r_tok;
    logic   q_empty, q_pop, r_push, r_full;

    dfg_fifo #(.WIDTH(TOKEN_W), .DEPTH(FIFO_DEPTH)) u_qin (
      .clk(clk), .rst_n(rst_n),
      .push(fork_push), .wdata(fork_tok),
      .pop(q_pop), .rdata(q_tok),
      .full(arm_full[k]), .empty(q_empty)
    );

    dfg_branch #(.DOUBLE(k == 1)) u_op (
      .clk(clk), .rst_n(rst_n),
      .in_valid(!q_empty), .in_tok(q_tok), .in_pop(q_pop),
      .out_full(r_full), .out_push(r_push), .out_tok(r_tok)
    );

    dfg_fifo #(.WIDTH(TOKEN_W), .DEPTH(FIFO_DEPTH)) u_qout (
      .clk(clk), .rst_n(rst_n),
      .push(r_push), .wdata(r_tok),
      .pop(join_pop), .rdata(arm_tok[k]),
      .full(r_full), .empty(arm_empty[k])
    );
  end

  assign join_b_last = arm_tok[0].last;
  assign join_c_last = arm_tok[1].last;

  dfg_join u_join (
    .clk(clk), .rst_n(rst_n),
    .b_valid(!arm_empty[0]), .b_tok(arm_tok[0]),
    .c_valid(!arm_empty[1]), .c_tok(arm_tok[1]),
    .pop(join_pop),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready)
  );
endmodule

// File: rtl/dfg_diamond_chk.sv
module dfg_diamond_chk #(
  parameter int FRAME_LEN = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       out_ready,
  input logic       fork_push,
  input logic [1:0] arm_full,
  input logic [1:0] arm_empty,
  input logic       join_pop,
  input logic       join_b_last,
  input logic       join_c_last
);
  localparam int CW = $clog2(FRAME_LEN);
  logic [CW-1:0] ocnt;
  logic          ofire;

  assign ofire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)     ocnt <= '0;
    else if (ofire) ocnt <= (ocnt == CW'(FRAME_LEN - 1)) ? '0 : ocnt + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  p_join_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    join_pop |-> (join_b_last == join_c_last));

  p_join_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    join_pop |-> (arm_empty == 2'b00));

  p_last_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ofire |-> (out_last == (ocnt == CW'(FRAME_LEN - 1))));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fork_push |-> (arm_full == 2'b00));

  p_in_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (arm_full != 2'b00)) |-> !in_ready);

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind dfg_diamond dfg_diamond_chk #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
  .out_ready(out_ready),
  .fork_push(fork_push), .arm_full(arm_full), .arm_empty(arm_empty),
  .join_pop(join_pop), .join_b_last(join_b_last), .join_c_last(join_c_last)
);

// File: tb/dfg_diamond_test.sv
`timescale 1ns/1ps
module dfg_diamond_test;
  localparam int N     = 8;
  localparam int DEPTH = 4;
  localparam int WD    = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_ready = 1'b0;

  always #5 clk = ~clk;

  dfg_diamond #(.FRAME_LEN(N), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .out_ready(out_ready)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0, in_idx = 0, n_out = 0;
  int exp_q[$];
  bit last_acc;
  bit prev_stall = 0;
  logic [7:0] prev_data;
  logic prev_last;
  bit ph_burst = 0;
  int burst_stalls = 0, first_oc = -1, last_oc = -1;
  bit done = 0;

  function automatic logic [7:0] model(input logic [7:0] x);
    return 8'((int'(x) << 4) - int'(x) + 25);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(input logic iv, input logic [7:0] id, input logic ordy);
    int e;
    @(negedge clk);
    in_valid = iv; in_data = id; out_ready = ordy;
    #4;
    cyc++;
    if (prev_stall) begin
      chk(out_valid == 1'b1, "R9 valid held", int'(out_valid), 1);
      chk(out_data == prev_data && out_last == prev_last, "R9 data held",
          int'(out_data), int'(prev_data));
    end
    prev_stall = out_valid && !out_ready;
    prev_data  = out_data;
    prev_last  = out_last;
    last_acc = in_valid && in_ready;
    if (ph_burst && in_valid && !in_ready) burst_stalls++;
    if (last_acc) begin
      exp_q.push_back({23'd0, (in_idx % N) == (N - 1), model(in_data)});
      in_idx++;
    end
    if (out_valid && out_ready) begin
      if (ph_burst) begin
        if (first_oc < 0) first_oc = cyc;
        last_oc = cyc;
      end
      n_out++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected output", int'(out_data), -1);
      end else begin
        e = exp_q.pop_front();
        chk(out_data == e[7:0], "R2 data", int'(out_data), e & 255);
        chk(out_last == e[8], "R7 last", int'(out_last), (e >> 8) & 1);
      end
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(WD * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int acc;
    int v;
    logic [15:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);

    // R4: full-rate burst of 32 samples
    ph_burst = 1;
    for (int i = 0; i < 32; i++) step(1'b1, 8'(i * 7 + 3), 1'b1);
    for (int i = 0; i < 12; i++) step(1'b0, 8'h00, 1'b1);
    ph_burst = 0;
    chk(burst_stalls == 0, "R4 in_ready stayed high", burst_stalls, 0);
    chk(last_oc - first_oc == 31, "R4 consecutive outputs", last_oc - first_oc, 31);

    // R8: capacity under full backpressure
    acc = 0; v = 100;
    for (int i = 0; i < 24; i++) begin
      step(1'b1, 8'(v), 1'b0);
      if (last_acc) begin acc++; v++; end
    end
    chk(acc == 2 * DEPTH + 2, "R8 capacity", acc, 2 * DEPTH + 2);
    chk(in_ready == 1'b0, "R8 in_ready low when full", int'(in_ready), 0);
    for (int i = 0; i < 20; i++) step(1'b0, 8'h00, 1'b1);

    // R2/R3/R7: every input value with random gaps and backpressure
    lfsr = 16'hACE1; v = 0;
    while (v < 256) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], 8'(v), lfsr[5] | lfsr[9] | lfsr[11]);
      if (last_acc) v++;
    end
    // long stall then drain
    for (int i = 0; i < 16; i++) step(1'b0, 8'h00, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b0, 8'h00, 1'b1);

    chk(exp_q.size() == 0, "R3 nothing left pending", exp_q.size(), 0);
    chk(n_out == in_idx, "R3 output count", n_out, in_idx);
    chk(out_valid == 1'b0, "R6 idle after drain", int'(out_valid), 0);
    summary();
  end
endmodule